// File: doc/BRIEF.md
# Cascade Fault Output Aggregator

This block gathers the fault conditions of a hardware monitor into one shared, active-low, open-drain cascade line. Other monitor controllers on the board watch that line and can react, for example by raising their own fan speeds, without a host processor taking part. The block does not measure anything. It receives measured values, limits and ready-made flags, and it applies per-channel action registers that decide which conditions may pull the line.

The block has three temperature channels, two fan channels and two analog-input channels. Each temperature and analog channel has an upper-limit check and a lower-limit check. The lower-limit check has a programmable crossing direction. Each fan channel trips on a tachometer reading above its limit or on its active-low fail pin. A hot-plug event, a software force bit and fault requests from the general-purpose pins pull the line without any further enable.

All sources are ORed together and registered once. The registered result drives the pad low, and the pad is released (high-Z) otherwise.

Top module: `cascade_fault_out`

## Requirements
- R1: While `fault_drive` is 1, `cfault_n` is driven to 0. While it is 0, `cfault_n` is high-Z. During reset and immediately after reset, `fault_drive` is 0, whatever the inputs are.
- R2: When `hotplug_evt` is 1, `fault_drive` is 1 one clock later. No enable applies.
- R3: When `sw_force` is 1, `fault_drive` is 1 one clock later.
- R4: When any bit of `gpio_fault_req` is 1, `fault_drive` is 1 one clock later.
- R5: A temperature channel whose action bit 0 is set contributes a fault when its value is strictly greater than its upper limit. Comparisons are unsigned 8-bit.
- R6: A temperature channel whose action bit 4 is set contributes a fault on its lower limit. The direction comes from action bit 3: 0 trips when the value is strictly below the limit, and 1 trips when the value is strictly above it. Equality never trips.
- R7: A fan channel whose action bit 0 is set contributes a fault when its tach value is strictly greater than its tach limit.
- R8: A fan channel whose action bit 0 is set contributes a fault while its `fan_fail_n` pin is 0. The pin passes through a two-flop synchronizer, so a falling pin reaches `fault_drive` on the third rising clock edge.
- R9: Each analog-input channel follows the same rules as a temperature channel: bit 0 enables the upper limit, bit 4 enables the lower limit, and bit 3 sets the lower-limit direction.
- R10: `fault_drive` is registered. It follows the OR of all sources one clock later and returns to 0 one clock after every source is inactive.
- R11: A channel whose enable bits are clear contributes nothing, whatever its value or pin. For temperature and analog channels these are bits 0 and 4. For fan channels this is bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hotplug_evt | input | 1 | Hot-plug event, pulls the line unconditionally |
| sw_force | input | 1 | Software force bit |
| gpio_fault_req | input | 6 | Fault requests from general-purpose pins |
| temp_val | input | 24 | Temperature values, 8 bits per channel, channel 0 in the low byte |
| temp_hi_lim | input | 24 | Temperature upper limits |
| temp_lo_lim | input | 24 | Temperature lower limits |
| temp_act | input | 24 | Temperature action bytes |
| fan_tach | input | 16 | Fan tach measurements |
| fan_tach_lim | input | 16 | Fan tach limits |
| fan_fail_n | input | 2 | Asynchronous active-low fan fail pins |
| fan_act | input | 16 | Fan action bytes |
| ain_val | input | 16 | Analog-input values |
| ain_hi_lim | input | 16 | Analog-input upper limits |
| ain_lo_lim | input | 16 | Analog-input lower limits |
| ain_act | input | 16 | Analog-input action bytes |
| fault_drive | output | 1 | Registered pull-down enable for the cascade line |
| cfault_n | inout | 1 | Open-drain cascade fault line |

## Verification
The channel assertions assume that values, limits and action bytes are stable, synchronous inputs that are valid at every rising edge. Only `fan_fail_n` may change asynchronously. The bench respects this by changing every input on the falling edge, and it samples `fault_drive` on the falling edge that follows the register's update. The release of the pad is not observed directly, because the bench has no pull-up. It is checked through `fault_drive` instead.

// File: rtl/cfo_pkg.sv
package cfo_pkg;
  localparam int VAL_W      = 8;
  localparam int ACT_W      = 8;
  localparam int ACT_HI_EN  = 0;
  localparam int ACT_LO_DIR = 3;
  localparam int ACT_LO_EN  = 4;

  // unsigned strict greater-than
  function automatic logic over_lim(input logic [VAL_W-1:0] v, input logic [VAL_W-1:0] lim);
    return v > lim;
  endfunction

  // directional low-limit crossing: dir 0 -> below, dir 1 -> above
  function automatic logic lo_cross(input logic [VAL_W-1:0] v, input logic [VAL_W-1:0] lim,
                                    input logic dir);
    return dir ? (v > lim) : (v < lim);
  endfunction
endpackage

// File: rtl/cfo_limit_chan.sv
module cfo_limit_chan
  import cfo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VAL_W-1:0] val,
  input  logic [VAL_W-1:0] hi_lim,
  input  logic [VAL_W-1:0] lo_lim,
  input  logic [ACT_W-1:0] act,
  output logic             fault
);
  logic hi_evt, lo_evt;
  logic unused_act;

  assign hi_evt = act[ACT_HI_EN] & over_lim(val, hi_lim);
  assign lo_evt = act[ACT_LO_EN] & lo_cross(val, lo_lim, act[ACT_LO_DIR]);
  assign fault  = hi_evt | lo_evt;
  assign unused_act = ^{act[ACT_W-1:ACT_LO_EN+1], act[ACT_LO_DIR-1:ACT_HI_EN+1]};

  AST_HI_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (act[0] && (val > hi_lim)) |-> fault); // R5
  AST_LO_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    (act[4] && !act[3] && (val < lo_lim)) |-> fault); // R6
  AST_LO_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (act[4] && act[3] && (val > lo_lim)) |-> fault); // R6
  AST_CHAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!act[0] && !act[4]) |-> !fault); // R11
endmodule

// File: rtl/cfo_fan_chan.sv
module cfo_fan_chan
  import cfo_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VAL_W-1:0] tach,
  input  logic [VAL_W-1:0] tach_lim,
  input  logic             fail_n,
  input  logic [ACT_W-1:0] act,
  output logic             fault
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic pin_evt, tach_evt;
  logic unused_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], fail_n};
  end

  assign pin_evt  = act[ACT_HI_EN] & ~sync_q[SYNC_STAGES-1];
  assign tach_evt = act[ACT_HI_EN] & over_lim(tach, tach_lim);
  assign fault    = pin_evt | tach_evt;
  assign unused_act = ^act[ACT_W-1:ACT_HI_EN+1];

  AST_TACH_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (act[0] && (tach > tach_lim)) |-> fault); // R7
  AST_PIN_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (act[0] && !sync_q[SYNC_STAGES-1]) |-> fault); // R8
  AST_FAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !act[0] |-> !fault); // R11
endmodule

// File: rtl/cascade_fault_out.sv
module cascade_fault_out
  import cfo_pkg::*;
#(
  parameter int N_TEMP = 3,
  parameter int N_FAN  = 2,
  parameter int N_AIN  = 2,
  parameter int N_GPIO = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hotplug_evt,
  input  logic                    sw_force,
  input  logic [N_GPIO-1:0]       gpio_fault_req,
  input  logic [N_TEMP*VAL_W-1:0] temp_val,
  input  logic [N_TEMP*VAL_W-1:0] temp_hi_lim,
  input  logic [N_TEMP*VAL_W-1:0] temp_lo_lim,
  input  logic [N_TEMP*ACT_W-1:0] temp_act,
  input  logic [N_FAN*VAL_W-1:0]  fan_tach,
  input  logic [N_FAN*VAL_W-1:0]  fan_tach_lim,
  input  logic [N_FAN-1:0]        fan_fail_n,
  input  logic [N_FAN*ACT_W-1:0]  fan_act,
  input  logic [N_AIN*VAL_W-1:0]  ain_val,
  input  logic [N_AIN*VAL_W-1:0]  ain_hi_lim,
  input  logic [N_AIN*VAL_W-1:0]  ain_lo_lim,
  input  logic [N_AIN*ACT_W-1:0]  ain_act,
  output logic                    fault_drive,
  inout  wire                     cfault_n
);
  localparam int N_CHAN = N_TEMP + N_FAN + N_AIN;

  logic [N_CHAN-1:0] chan_fault;
  logic direct_evt, any_src;

  for (genvar t = 0; t < N_TEMP; t++) begin : g_temp
    cfo_limit_chan u_chan (
      .clk(clk), .rst_n(rst_n),
      .val(temp_val[t*VAL_W +: VAL_W]), .hi_lim(temp_hi_lim[t*VAL_W +: VAL_W]),
      .lo_lim(temp_lo_lim[t*VAL_W +: VAL_W]), .act(temp_act[t*ACT_W +: ACT_W]),
      .fault(chan_fault[t]));
  end

  for (genvar a = 0; a < N_AIN; a++) begin : g_ain
    cfo_limit_chan u_chan (
      .clk(clk), .rst_n(rst_n),
      .val(ain_val[a*VAL_W +: VAL_W]), .hi_lim(ain_hi_lim[a*VAL_W +: VAL_W]),
      .lo_lim(ain_lo_lim[a*VAL_W +: VAL_W]), .act(ain_act[a*ACT_W +: ACT_W]),
      .fault(chan_fault[N_TEMP+a]));
  end

  for (genvar f = 0; f < N_FAN; f++) begin : g_fan
    cfo_fan_chan #(.SYNC_STAGES(2)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .tach(fan_tach[f*VAL_W +: VAL_W]), .tach_lim(fan_tach_lim[f*VAL_W +: VAL_W]),
      .fail_n(fan_fail_n[f]), .act(fan_act[f*ACT_W +: ACT_W]),
      .fault(chan_fault[N_TEMP+N_AIN+f]));
  end

  assign direct_evt = hotplug_evt | sw_force | (|gpio_fault_req);
  assign any_src    = direct_evt | (|chan_fault);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_drive <= 1'b0;
    else        fault_drive <= any_src;
  end

  assign cfault_n = fault_drive ? 1'b0 : 1'bz;

  AST_PAD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    fault_drive |-> (cfault_n == 1'b0)); // R1
  AST_HOTPLUG: assert property (@(posedge clk) disable iff (!rst_n)
    hotplug_evt |=> fault_drive); // R2
  AST_SW_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    sw_force |=> fault_drive); // R3
  AST_GPIO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (|gpio_fault_req) |=> fault_drive); // R4
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!hotplug_evt && !sw_force && gpio_fault_req == '0 && chan_fault == '0)
      |=> !fault_drive); // R10
endmodule

// File: tb/tb_cascade_fault_out.sv
module tb_cascade_fault_out;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hotplug_evt, sw_force;
  logic [5:0]  gpio_fault_req;
  logic [23:0] temp_val, temp_hi_lim, temp_lo_lim, temp_act;
  logic [15:0] fan_tach, fan_tach_lim, fan_act;
  logic [1:0]  fan_fail_n;
  logic [15:0] ain_val, ain_hi_lim, ain_lo_lim, ain_act;
  logic fault_drive;
  wire  cfault_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cascade_fault_out dut (
    .clk(clk), .rst_n(rst_n), .hotplug_evt(hotplug_evt), .sw_force(sw_force),
    .gpio_fault_req(gpio_fault_req), .temp_val(temp_val), .temp_hi_lim(temp_hi_lim),
    .temp_lo_lim(temp_lo_lim), .temp_act(temp_act), .fan_tach(fan_tach),
    .fan_tach_lim(fan_tach_lim), .fan_fail_n(fan_fail_n), .fan_act(fan_act),
    .ain_val(ain_val), .ain_hi_lim(ain_hi_lim), .ain_lo_lim(ain_lo_lim),
    .ain_act(ain_act), .fault_drive(fault_drive), .cfault_n(cfault_n));

  // vector: {exp, kind[1:0], idx[1:0], req[3:0], misc[7:0], val, hi, lo, act}
  // kind 0 temp, 1 ain, 2 fan tach (val=tach, hi=limit), 3 direct (misc: [7]hot [6]force [5:0]gpio)
  localparam int NV = 19;
  localparam logic [48:0] VEC [NV] = '{
    {1'b1, 2'd0, 2'd0, 4'd5,  8'h00, 8'h91, 8'h90, 8'h00, 8'h01}, // R5 above
    {1'b0, 2'd0, 2'd1, 4'd5,  8'h00, 8'h90, 8'h90, 8'h00, 8'h01}, // R5 equal
    {1'b0, 2'd0, 2'd2, 4'd11, 8'h00, 8'hFF, 8'h10, 8'h00, 8'h00}, // R11 disabled
    {1'b1, 2'd0, 2'd0, 4'd6,  8'h00, 8'h0F, 8'hFF, 8'h10, 8'h10}, // R6 below dir0
    {1'b0, 2'd0, 2'd1, 4'd6,  8'h00, 8'h10, 8'hFF, 8'h10, 8'h10}, // R6 equal
    {1'b1, 2'd0, 2'd2, 4'd6,  8'h00, 8'h11, 8'hFF, 8'h10, 8'h18}, // R6 above dir1
    {1'b0, 2'd0, 2'd0, 4'd6,  8'h00, 8'h0F, 8'hFF, 8'h10, 8'h18}, // R6 below dir1
    {1'b0, 2'd0, 2'd0, 4'd11, 8'h00, 8'h11, 8'hFF, 8'h10, 8'h08}, // R11 dir only
    {1'b1, 2'd1, 2'd0, 4'd9,  8'h00, 8'h81, 8'h80, 8'h00, 8'h01}, // R9 high
    {1'b1, 2'd1, 2'd1, 4'd9,  8'h00, 8'h05, 8'hFF, 8'h06, 8'h10}, // R9 low dir0
    {1'b0, 2'd1, 2'd1, 4'd9,  8'h00, 8'h05, 8'hFF, 8'h06, 8'h18}, // R9 low dir1
    {1'b1, 2'd2, 2'd0, 4'd7,  8'h00, 8'h41, 8'h40, 8'h00, 8'h01}, // R7 over
    {1'b0, 2'd2, 2'd1, 4'd11, 8'h00, 8'h41, 8'h40, 8'h00, 8'h00}, // R11 fan off
    {1'b0, 2'd2, 2'd1, 4'd7,  8'h00, 8'h40, 8'h40, 8'h00, 8'h01}, // R7 equal
    {1'b1, 2'd3, 2'd0, 4'd2,  8'h80, 8'h00, 8'h00, 8'h00, 8'h00}, // R2 hot-plug
    {1'b1, 2'd3, 2'd0, 4'd3,  8'h40, 8'h00, 8'h00, 8'h00, 8'h00}, // R3 force
    {1'b1, 2'd3, 2'd0, 4'd4,  8'h20, 8'h00, 8'h00, 8'h00, 8'h00}, // R4 gpio5
    {1'b1, 2'd3, 2'd0, 4'd4,  8'h01, 8'h00, 8'h00, 8'h00, 8'h00}, // R4 gpio0
    {1'b0, 2'd3, 2'd0, 4'd10, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}  // R10 all quiet
  };

  task automatic quiet();
    hotplug_evt = 0; sw_force = 0; gpio_fault_req = '0;
    temp_val = {3{8'h80}}; temp_hi_lim = {3{8'hFF}}; temp_lo_lim = '0; temp_act = '0;
    fan_tach = '0; fan_tach_lim = {2{8'hFF}}; fan_fail_n = 2'b11; fan_act = '0;
    ain_val = {2{8'h80}}; ain_hi_lim = {2{8'hFF}}; ain_lo_lim = '0; ain_act = '0;
  endtask

  task automatic check(input logic exp, input int req, input string what);
    checks++;
    if (fault_drive !== exp || (exp && cfault_n !== 1'b0)) begin
      errors++;
      $display("FAIL R%0d %s: fault_drive=%b cfault_n=%b expected drive=%b", req, what,
               fault_drive, cfault_n, exp);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL R10 watchdog expired: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    quiet();
    sw_force = 1'b1;
    repeat (3) @(negedge clk);
    check(1'b0, 1, "R1 held low during reset");
    rst_n = 1'b1;
    sw_force = 1'b0;
    @(posedge clk); @(negedge clk);
    check(1'b0, 1, "R1 released after reset");

    for (int i = 0; i < NV; i++) begin
      logic [48:0] v;
      int k, x;
      v = VEC[i];
      quiet();
      k = int'(v[47:46]); x = int'(v[45:44]);
      case (k)
        0: begin
          temp_val[x*8 +: 8] = v[31:24]; temp_hi_lim[x*8 +: 8] = v[23:16];
          temp_lo_lim[x*8 +: 8] = v[15:8]; temp_act[x*8 +: 8] = v[7:0];
        end
        1: begin
          ain_val[x*8 +: 8] = v[31:24]; ain_hi_lim[x*8 +: 8] = v[23:16];
          ain_lo_lim[x*8 +: 8] = v[15:8]; ain_act[x*8 +: 8] = v[7:0];
        end
        2: begin
          fan_tach[x*8 +: 8] = v[31:24]; fan_tach_lim[x*8 +: 8] = v[23:16];
          fan_act[x*8 +: 8] = v[7:0];
        end
        default: begin
          hotplug_evt = v[39]; sw_force = v[38]; gpio_fault_req = v[37:32];
        end
      endcase
      @(posedge clk); @(negedge clk);
      check(v[48], int'(v[43:40]), $sformatf("vector %0d", i));
    end

    // R10: one-clock latency in both directions
    quiet(); @(posedge clk); @(negedge clk);
    sw_force = 1'b1;
    #1 check(1'b0, 10, "R10 no change before edge");
    @(posedge clk); @(negedge clk);
    check(1'b1, 10, "R10 asserted one clock later");
    sw_force = 1'b0;
    @(posedge clk); @(negedge clk);
    check(1'b0, 10, "R10 released one clock after sources clear");

    // R8: fan fail pin through two-flop sync, third edge
    fan_act[7:0] = 8'h01;
    fan_fail_n[0] = 1'b0;
    @(posedge clk); @(negedge clk);
    check(1'b0, 8, "R8 edge 1");
    @(posedge clk); @(negedge clk);
    check(1'b0, 8, "R8 edge 2");
    @(posedge clk); @(negedge clk);
    check(1'b1, 8, "R8 edge 3");
    fan_fail_n[0] = 1'b1;
    repeat (3) @(posedge clk); @(negedge clk);
    check(1'b0, 8, "R8 pin release");

    // R11: fan pin low with enable clear
    fan_act = '0;
    fan_fail_n = 2'b00;
    repeat (5) @(posedge clk); @(negedge clk);
    check(1'b0, 11, "R11 fan pin ignored when disabled");
    quiet();
    repeat (3) @(posedge clk); @(negedge clk);

    // R1: pad pulled low while asserted
    hotplug_evt = 1'b1;
    @(posedge clk); @(negedge clk);
    check(1'b1, 1, "R1 pad pulled low");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule